// File: doc/BRIEF.md
# Receive Length Error Counter

This block inspects the byte length of every received frame as the frame ends and decides whether it is too short or too long. The length is given in bytes and covers the frame from the destination address through the FCS; the preamble and start delimiter are not included. Frames shorter than 64 bytes are short. A frame is too long above 1522 bytes, or above 16384 bytes when the long-frame enable is set. For each frame, the block gives one-cycle short and long flags that other receive logic can use.

A frame that is out of range adds one to a 32-bit statistic, but only if the destination address filter passed that frame. A pass can come from a broadcast match or from an individual or multicast match; computing that match is the job of other logic. The statistic is read-to-clear: the value read in a cycle is the one on the read data port, and the counter clears at the next edge. If a counted frame ends in the same cycle as the read, the counter restarts at one, so that frame is not lost. The counter holds at all-ones and does not wrap.

The frame-end input is a one-cycle valid pulse that carries the length and the filter flag. The block never applies back-pressure: it accepts a frame-end in any cycle, including back-to-back cycles and the cycle of a read. For that reason the interface has no ready signal.

Top module: `rx_len_err_counter`

## Requirements
- R1: A frame changes the count only when its address-filter-pass input is high in its frame-end cycle. A failing frame leaves the count unchanged, whatever its length.
- R2: A frame with length below 64 is short. A length of exactly 64 is in range.
- R3: With long-frame enable low, a length above 1522 is long. A length of exactly 1522 is in range.
- R4: With long-frame enable high, a length above 16384 is long. Lengths of 1523 and 16384 are in range.
- R5: The short and long flags are high for exactly the one cycle that follows a frame-end pulse whose length is out of range. This holds whatever the filter input is. The flags are low after cycles that have no frame-end pulse.
- R6: Reset clears the count and both flags to zero.
- R7: The read data port shows the current count at all times. One cycle of the read strobe clears the count at the next edge.
- R8: The count saturates at all-ones. Further counted frames leave it at all-ones.
- R9: A counted frame in the same cycle as a read leaves the count at one.
- R10: A counted frame, with no read in that cycle, raises the count by exactly one at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle frame-end pulse; always accepted |
| frm_len | input | 16 | Frame length in bytes, FCS included, valid with frm_valid |
| frm_filt_pass | input | 1 | Frame passed the destination address filter, valid with frm_valid |
| long_frm_en | input | 1 | Raises the upper length limit from 1522 to 16384 |
| stat_rd | input | 1 | Read strobe; clears the count at the next edge |
| stat_rdata | output | 32 | Current error count |
| flag_short | output | 1 | Previous frame-end was short |
| flag_long | output | 1 | Previous frame-end was long |

## Verification
Two events can fall in the same cycle: the increment from a counted error frame and the clear from a read. The bench causes this by asserting the read strobe in the same cycle as a short frame, and in the same cycle as a long frame, that passed the filter. It also repeats this while the counter sits at all-ones. A behavioural model predicts the count of one after each such cycle, and the bench compares it with the design on every clock. A second instance with a narrow counter is pushed into saturation so that a read can be made while the counter is full.

// File: rtl/rlec_pkg.sv
package rlec_pkg;
  typedef struct packed {
    logic is_short;
    logic is_long;
  } len_class_t;
endpackage

// File: rtl/rlec_len_check.sv
module rlec_len_check #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int STD_MAX = 1522,
  parameter int JUM_MAX = 16384
) (
  input  logic [LEN_W-1:0]     len,
  input  logic                 long_en,
  output rlec_pkg::len_class_t cls
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_L = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] JUM_L = LEN_W'(JUM_MAX);

  logic [LEN_W-1:0] upper;

  always_comb begin
    upper        = long_en ? JUM_L : STD_L;
    cls.is_short = (len < MIN_L);
    cls.is_long  = (len > upper);
  end
endmodule

// File: rtl/rlec_sat_counter.sv
module rlec_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= inc ? ONE : '0;
    else if (inc && cnt != FULL)
      cnt <= cnt + ONE;
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !inc |=> cnt == '0); // R7
  AST_READ_KEEPS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    clr && inc |=> cnt == ONE); // R9
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && cnt == FULL |=> cnt == FULL); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && inc && cnt != FULL |=> cnt == $past(cnt) + ONE); // R10
endmodule

// File: rtl/rx_len_err_counter.sv
module rx_len_err_counter #(
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 64,
  parameter int STD_MAX = 1522,
  parameter int JUM_MAX = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_filt_pass,
  input  logic             long_frm_en,
  input  logic             stat_rd,
  output logic [CNT_W-1:0] stat_rdata,
  output logic             flag_short,
  output logic             flag_long
);
  rlec_pkg::len_class_t cls;
  logic                 bad_len;
  logic                 count_it;

  rlec_len_check #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .STD_MAX(STD_MAX), .JUM_MAX(JUM_MAX)
  ) u_check (
    .len(frm_len), .long_en(long_frm_en), .cls(cls)
  );

  assign bad_len  = cls.is_short | cls.is_long;
  assign count_it = frm_valid & frm_filt_pass & bad_len;

  rlec_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(count_it), .clr(stat_rd), .cnt(stat_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_short <= 1'b0;
      flag_long  <= 1'b0;
    end else begin
      flag_short <= frm_valid & cls.is_short;
      flag_long  <= frm_valid & cls.is_long;
    end
  end

  AST_FILTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd && !(frm_valid && frm_filt_pass) |=> $stable(stat_rdata)); // R1
  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !flag_short && !flag_long); // R5
  AST_SHORT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_len < LEN_W'(MIN_LEN) |=> flag_short && !flag_long); // R2
  AST_LONG_STD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !long_frm_en && frm_len > LEN_W'(STD_MAX) |=> flag_long); // R3
  AST_LONG_JUMBO: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && long_frm_en && frm_len <= LEN_W'(JUM_MAX)
      && frm_len >= LEN_W'(MIN_LEN) |=> !flag_long && !flag_short); // R4
endmodule

// File: tb/sim_rx_len_err_counter.sv
module sim_rx_len_err_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic        frm_filt_pass = 1'b0;
  logic        long_frm_en = 1'b0;
  logic        stat_rd = 1'b0;
  logic [31:0] stat_rdata;
  logic        flag_short, flag_long;
  logic [3:0]  small_rdata;
  logic        small_short, small_long;

  int compared = 0;
  int mismatched = 0;
  longint exp_cnt = 0;
  int exp_small = 0;
  bit exp_short = 0, exp_long = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_len_err_counter u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_filt_pass(frm_filt_pass), .long_frm_en(long_frm_en), .stat_rd(stat_rd),
    .stat_rdata(stat_rdata), .flag_short(flag_short), .flag_long(flag_long)
  );

  rx_len_err_counter #(.CNT_W(4)) u1 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_filt_pass(frm_filt_pass), .long_frm_en(long_frm_en), .stat_rd(stat_rd),
    .stat_rdata(small_rdata), .flag_short(small_short), .flag_long(small_long)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "count", longint'(stat_rdata), exp_cnt);
    check(tag, "short flag", longint'(flag_short), longint'(exp_short));
    check(tag, "long flag", longint'(flag_long), longint'(exp_long));
    check(tag, "narrow count", longint'(small_rdata), longint'(exp_small));
  endtask

  task automatic step(bit v, int len, bit filt, bit lpe, bit rd, string tag);
    int lim;
    bit sh, lo, inc;
    frm_valid = v; frm_len = 16'(len); frm_filt_pass = filt;
    long_frm_en = lpe; stat_rd = rd;
    @(posedge clk);
    lim = lpe ? 16384 : 1522;
    sh = v && (len < 64);
    lo = v && (len > lim);
    inc = v && filt && (sh || lo);
    exp_short = sh; exp_long = lo;
    if (rd) begin
      exp_cnt = inc ? 1 : 0;
      exp_small = inc ? 1 : 0;
    end else if (inc) begin
      if (exp_cnt < 64'hFFFF_FFFF) exp_cnt++;
      if (exp_small < 15) exp_small++;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R6");
    rst_n = 1'b1;
    // R2 short boundary
    step(1, 63, 1, 0, 0, "R2");
    step(1, 64, 1, 0, 0, "R2");
    step(1, 1, 1, 0, 0, "R2");
    // R3 standard upper boundary
    step(1, 1522, 1, 0, 0, "R3");
    step(1, 1523, 1, 0, 0, "R3");
    // R4 long-frame enable boundaries
    step(1, 1523, 1, 1, 0, "R4");
    step(1, 16384, 1, 1, 0, "R4");
    step(1, 16385, 1, 1, 0, "R4");
    step(1, 40, 1, 1, 0, "R4");
    // R1 filter fail: flags still follow length, count unchanged
    step(1, 10, 0, 0, 0, "R1");
    step(1, 2000, 0, 0, 0, "R1");
    step(1, 20000, 0, 1, 0, "R1");
    // R5 idle cycles and strobe-less lengths
    step(0, 10, 1, 0, 0, "R5");
    step(0, 3000, 1, 0, 0, "R5");
    // R10 back-to-back counted frames
    step(1, 30, 1, 0, 0, "R10");
    step(1, 1600, 1, 0, 0, "R10");
    // R7 read clears
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // R9 read colliding with counted frames
    step(1, 20, 1, 0, 0, "R9");
    step(1, 20, 1, 0, 1, "R9");
    step(1, 9000, 1, 0, 1, "R9");
    step(1, 100, 1, 0, 1, "R9");
    // R8 saturation on the narrow instance
    for (int i = 0; i < 20; i++) step(1, 5, 1, 0, 0, "R8");
    step(1, 5, 1, 0, 1, "R9");
    for (int i = 0; i < 17; i++) step(1, 17000, 1, 1, 0, "R8");
    step(0, 0, 0, 0, 1, "R7");
    // mixed pattern
    for (int i = 0; i < 60; i++)
      step(i % 3 != 0, (i * 613) % 17500, i % 4 != 1, i % 5 == 0, i % 11 == 0, "R10");
    rst_n = 1'b0;
    @(posedge clk);
    exp_cnt = 0; exp_small = 0; exp_short = 0; exp_long = 0;
    @(negedge clk);
    compare_all("R6");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule